// File: doc/BRIEF.md
# Debug Data Nibble FIFO Serializer

This block sits between a processor core's internal bus and a narrow debug data port. The core offers 32-bit trace items, such as taken-branch target addresses (including targets computed from registers) and selected operand read or write values. Each item carries a size code of byte, word or long. The block holds up to two items and sends each one out four bits per clock, least significant nibble first, together with a nibble-valid flag.

The capture side is a valid/ready stream. The core raises `push_valid` with `push_data` and `push_size`, and an item is taken on any rising edge where `push_valid` and `push_ready` are both high. Back-pressure appears only when both storage slots hold items that are not yet fully sent. In that case `push_ready` drops and `stall` rises while `push_valid` is held. The core must then keep its item steady until `push_ready` returns. A slot frees in the cycle that its final nibble is on the port, so a push in that cycle is accepted. The output side has no back-pressure: one nibble leaves on every clock while anything is held. In every other situation, capture and output cost the core no cycles.

Top module: `dbgn_nibble_fifo`

## Requirements
- R1: After reset the buffer is empty: `nib_valid` is 0, `nib_data` is 0, `push_ready` is 1 and `stall` is 0.
- R2: An item accepted into an empty buffer puts its first nibble on `nib_data` in the cycle after the accepting edge. Its nibbles follow on consecutive cycles, least significant first, so nibble k is `push_data[4k+3:4k]`.
- R3: Size code 0 (byte) sends 2 nibbles, taken from bits 7:0. Size code 1 (word) sends 4 nibbles, taken from bits 15:0. Size codes 2 and 3 (long) send 8 nibbles.
- R4: Items leave in acceptance order, and the first nibble of one item follows the last nibble of the previous item with no idle cycle between them.
- R5: `push_ready` is 1 whenever fewer than two items are held.
- R6: `stall` equals `push_valid` AND NOT `push_ready`. It is therefore raised only when both slots hold unsent data and an item is waiting.
- R7: In the cycle that the final nibble of the head item is on the port, `push_ready` is 1 even with two items held. A push in that cycle is accepted without a stall.
- R8: While the buffer is empty, `nib_valid` is 0 and `nib_data` is 0.
- R9: No item is lost. An item held under stall is accepted on the first cycle that a slot frees, and all of its nibbles are output later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Core offers a trace item |
| push_ready | output | 1 | Block can accept the item this cycle |
| push_data | input | 32 | Trace item value |
| push_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| stall | output | 1 | Core must hold while set |
| nib_data | output | 4 | Debug data nibble |
| nib_valid | output | 1 | `nib_data` carries a nibble |

## Verification
The bench uses the default parameters: a 32-bit item, a 4-bit port and two slots. With these values every ordering of three pushed items of every size code can be swept, each with several idle gaps. The sweep reaches the empty, one-held and full states. It also covers a push that lands exactly on a final-nibble cycle and pushes held under stall across the mix of 2-, 4- and 8-cycle drains. Expected nibbles and ready timing are derived arithmetically from the accepted items.

// File: rtl/dbgn_pkg.sv
package dbgn_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONG2 = 2'd3
  } dbgn_size_e;

  // Number of nibbles an item of a given size spends on the port.
  function automatic int unsigned nib_count(input logic [1:0] sz,
                                            input int unsigned nib_w,
                                            input int unsigned data_w);
    case (sz)
      2'd0:    return 8 / nib_w;
      2'd1:    return 16 / nib_w;
      default: return data_w / nib_w;
    endcase
  endfunction

endpackage

// File: rtl/dbgn_slot_ring.sv
module dbgn_slot_ring #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_size,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head_data,
  output logic [1:0]        head_size,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [1:0]        slot_size [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_data[g] <= '0;
        slot_size[g] <= '0;
      end else if (wr_en && (wr_ptr == PTR_W'(g))) begin
        slot_data[g] <= wr_data;
        slot_size[g] <= wr_size;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_next(wr_ptr);
      if (rd_en) rd_ptr <= ptr_next(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data = slot_data[rd_ptr];
  assign head_size = slot_size[rd_ptr];

endmodule

// File: rtl/dbgn_nib_ser.sv
module dbgn_nib_ser
  import dbgn_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4,
  localparam int MAX_NIB = DATA_W / NIB_W,
  localparam int IDX_W   = (MAX_NIB > 1) ? $clog2(MAX_NIB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic [DATA_W-1:0] head_data,
  input  logic [1:0]        head_size,
  output logic [NIB_W-1:0]  nib_data,
  output logic              nib_valid,
  output logic              last,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W:0]      nnib;
  logic [DATA_W-1:0]   shifted;

  always_comb begin
    nnib    = (IDX_W + 1)'(nib_count(head_size, NIB_W, DATA_W));
    shifted = head_data >> (32'(idx) * NIB_W);
  end

  assign nib_valid = head_valid;
  assign last      = head_valid && ({1'b0, idx} == (nnib - 1'b1));
  assign nib_data  = head_valid ? shifted[NIB_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx <= '0;
    else if (last)       idx <= '0;
    else if (head_valid) idx <= idx + 1'b1;
  end

endmodule

// File: rtl/dbgn_flow.sv
module dbgn_flow #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             push_valid,
  input  logic [CNT_W-1:0] count,
  input  logic             last,
  output logic             push_ready,
  output logic             stall,
  output logic             wr_en
);

  logic full;

  assign full       = (count == CNT_W'(DEPTH));
  assign push_ready = !full || last;
  assign stall      = push_valid && !push_ready;
  assign wr_en      = push_valid && push_ready;

endmodule

// File: rtl/dbgn_nibble_fifo.sv
module dbgn_nibble_fifo #(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4,
  parameter int DEPTH  = 2,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int MAX_NIB = DATA_W / NIB_W,
  localparam int IDX_W   = (MAX_NIB > 1) ? $clog2(MAX_NIB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic [1:0]        push_size,
  output logic              stall,
  output logic [NIB_W-1:0]  nib_data,
  output logic              nib_valid
);

  logic              wr_en;
  logic              last;
  logic [CNT_W-1:0]  occ;
  logic [DATA_W-1:0] head_data;
  logic [1:0]        head_size;
  logic [IDX_W-1:0]  idx;

  dbgn_slot_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ring_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (push_data),
    .wr_size   (push_size),
    .rd_en     (last),
    .head_data (head_data),
    .head_size (head_size),
    .count     (occ)
  );

  dbgn_nib_ser #(.DATA_W(DATA_W), .NIB_W(NIB_W)) ser_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (occ != '0),
    .head_data  (head_data),
    .head_size  (head_size),
    .nib_data   (nib_data),
    .nib_valid  (nib_valid),
    .last       (last),
    .idx        (idx)
  );

  dbgn_flow #(.DEPTH(DEPTH)) flow_i (
    .push_valid (push_valid),
    .count      (occ),
    .last       (last),
    .push_ready (push_ready),
    .stall      (stall),
    .wr_en      (wr_en)
  );

endmodule

// File: rtl/dbgn_nibble_fifo_chk.sv
module dbgn_nibble_fifo_chk #(
  parameter int DATA_W = 32,
  parameter int NIB_W  = 4,
  parameter int DEPTH  = 2,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int MAX_NIB = DATA_W / NIB_W,
  localparam int IDX_W   = (MAX_NIB > 1) ? $clog2(MAX_NIB) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             push_ready,
  input logic             stall,
  input logic [NIB_W-1:0] nib_data,
  input logic             nib_valid,
  input logic [CNT_W-1:0] occ,
  input logic             last,
  input logic [IDX_W-1:0] idx
);

  assert_quiet_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_valid |-> (nib_data == '0));

  assert_stall_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (occ == CNT_W'(DEPTH)));

  assert_ready_below_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < CNT_W'(DEPTH)) |-> push_ready);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  assert_nibble_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid && !last) |=> (nib_valid && (idx == IDX_W'($past(idx) + 1'b1))));

  assert_free_on_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !(push_valid && push_ready)) |=> (occ == CNT_W'($past(occ) - 1'b1)));

endmodule

bind dbgn_nibble_fifo dbgn_nibble_fifo_chk #(
  .DATA_W(DATA_W), .NIB_W(NIB_W), .DEPTH(DEPTH)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .stall      (stall),
  .nib_data   (nib_data),
  .nib_valid  (nib_valid),
  .occ        (occ),
  .last       (last),
  .idx        (idx)
);

// File: tb/dbgn_nibble_fifo_tb.sv
`timescale 1ns/1ps
module dbgn_nibble_fifo_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0;
  logic        push_ready;
  logic [31:0] push_data = '0;
  logic [1:0]  push_size = '0;
  logic        stall;
  logic [3:0]  nib_data;
  logic        nib_valid;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  int exp_nib[$];   // expected nibble stream
  int exp_len[$];   // nibbles remaining per held item

  always #10 clk = ~clk;  // 50 MHz

  dbgn_nibble_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .push_size(push_size), .stall(stall),
    .nib_data(nib_data), .nib_valid(nib_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cycles);
    end
  endtask

  function automatic int size_nibs(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  // Monitor: runs mid-cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_rdy;
      bool_dummy();
      exp_rdy = (exp_len.size() < 2) || (exp_len[0] == 1);
      if (exp_nib.size() == 0) begin
        chk(!nib_valid, "R8 valid", int'(nib_valid), 0);
        chk(nib_data == 4'h0, "R8 data", int'(nib_data), 0);
      end else begin
        chk(nib_valid, "R4 no gap", int'(nib_valid), 1);
        chk(int'(nib_data) == exp_nib[0], "R2/R3 nibble", int'(nib_data), exp_nib[0]);
        void'(exp_nib.pop_front());
        exp_len[0] = exp_len[0] - 1;
      end
      if (exp_len.size() < 2)
        chk(push_ready, "R5 ready", int'(push_ready), 1);
      else if (exp_rdy)
        chk(push_ready, "R7 ready on last", int'(push_ready), 1);
      else
        chk(!push_ready, "R9 hold when full", int'(push_ready), 0);
      chk(stall == (push_valid && !exp_rdy), "R6 stall", int'(stall),
          int'(push_valid && !exp_rdy));
      if (exp_len.size() > 0 && exp_len[0] == 0) void'(exp_len.pop_front());
      if (push_valid && exp_rdy) begin
        for (int k = 0; k < size_nibs(push_size); k++)
          exp_nib.push_back(int'((push_data >> (4 * k)) & 32'hF));
        exp_len.push_back(size_nibs(push_size));
      end
    end
  end

  function automatic void bool_dummy();
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic push(input logic [31:0] d, input logic [1:0] s);
    bit took;
    push_valid = 1'b1; push_data = d; push_size = s;
    took = 1'b0;
    while (!took) begin
      @(negedge clk);
      took = push_ready;
      @(posedge clk); #1;
    end
    push_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    idle(2);
    // R1: reset state
    chk(!nib_valid, "R1 valid", int'(nib_valid), 0);
    chk(nib_data == 4'h0, "R1 data", int'(nib_data), 0);
    chk(push_ready, "R1 ready", int'(push_ready), 1);
    chk(!stall, "R1 stall", int'(stall), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // Sweep: three items of every size code, varying idle gap.
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int g = 0; g < 3; g++) begin
            logic [31:0] base;
            base = 32'h9E37_79B9 * (a * 48 + b * 12 + c * 3 + g + 1);
            push(base, 2'(a));
            idle(g);
            push({base[15:0], base[31:16]} ^ 32'h5A5A_C3C3, 2'(b));
            push(~base, 2'(c));
            while (exp_nib.size() != 0) idle(1);
            idle(1);
          end
    // R3: byte item carries only bits 7:0, then returns to empty.
    push(32'hFEDC_BA21, 2'd0);
    idle(4);
    chk(exp_nib.size() == 0, "R3 byte drained", exp_nib.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule